// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block models a synchronous single-port SRAM. Reads and writes may follow each other on every clock with no idle slot between them. Every control input is captured on the rising clock edge. A read is flow-through: the word at the address captured on an edge appears on the output during the cycle that follows that edge, through combinational logic from the array. A write uses a late-data scheme. The address and command are captured on one edge, and the data word is captured on the next enabled edge. That same edge may also start the next operation, so the data phase of a write overlaps the address phase of the next access.

The 36-bit word is split into four lanes. Each lane is eight data bits plus one parity bit, and each lane has its own active-low write select. A built-in two-bit burst counter steps the two lowest address bits through four beats, in linear or interleaved order. An active-low clock enable freezes the whole pipeline. The data bus is split into an input, an output and an output-enable flag. The output enable is masked by the external drive enable and by the internal state of the pipeline.

The array depth is a parameter. The default is a reduced depth of 256 words.

Top module: `zt_sram`

## Requirements
- R1: The device counts as selected at an enabled load edge only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load edge with any other combination deselects the device: `dout_oe` is 0 in the following cycle, and a write command on that edge stores nothing.
- R2: A load edge (`step`=0) with `wr_n`=1 while selected starts a read. During the following cycle, `dout` carries the word at `addr`. Reads may be issued back to back on consecutive edges.
- R3: A load edge with `wr_n`=0 while selected starts a write. `din` is captured on the next enabled edge, and that edge may load a new command. A read loaded on that same edge to the same address returns the new data.
- R4: Lane k covers `din[8k+7:8k]` and parity bit `din[32+k]`, for k = 0 to 3. It is written only when `byte_wr_n[k]`=0. The other lanes keep their previous contents.
- R5: `byte_wr_n` is taken on the data edge of each write beat, not on its address edge.
- R6: `dout_oe` is 0 in the following cases, whatever the value of `drive_en_n`: during the data cycle of a write, in the first cycle after a load that leaves the deselected state, and while the device is deselected.
- R7: `dout_oe` is 0 whenever `drive_en_n`=1. This enable acts combinationally, without waiting for a clock edge.
- R8: While `clk_en_n`=1, all state holds, including a write that is waiting for its data. No array write takes place. The held write completes on the next enabled edge, using the `din` present at that edge.
- R9: On an advance edge (`step`=1), the chip selects, `wr_n` and `addr` are ignored. The operation type is kept, and only the two low address bits change. With `order_ilv`=0 the low bits follow base+n mod 4. With `order_ilv`=1 they follow base XOR n. After four beats the sequence wraps back to the base. An advance while deselected leaves the device deselected.
- R10: After reset, the device is deselected, `dout_oe` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high freezes all state |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write command on a load edge, active low |
| step | input | 1 | 0 loads a new address and command, 1 advances the burst |
| byte_wr_n | input | 4 | Per-lane write selects, active low, taken on the data edge |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved; held static in use |
| drive_en_n | input | 1 | Asynchronous output drive enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data: lanes in bits 31:0, parity in bits 35:32 |
| dout | output | 36 | Read data, valid when `dout_oe` is 1 |
| dout_oe | output | 1 | Output drive enable for the data bus |

## Verification
On every cycle, the assertions check the following: a clock-enable stall freezes the command, address and emergence flag; an advance keeps the operation type and the upper address bits; the linear counter steps by one; and the output stays off during write data cycles, emergence cycles, deselection and a high drive enable. The bench scenarios cover what a property cannot see. This includes the data actually stored through the byte lanes, a write completing after a stall with the data present at the later edge, the interleaved beat order and its wrap, and a deselected write leaving memory untouched.

// File: rtl/zt_pkg.sv
package zt_pkg;

  // Operation held in the command stage
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

endpackage

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] base_in,
  input  logic             ilv,
  output logic [CNT_W-1:0] low
);

  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      cnt_q  <= '0;
    end else if (adv) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (ilv) low = base_q ^ cnt_q;
    else     low = base_q + cnt_q;
  end

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !ilv) |=> (ilv || low == CNT_W'($past(low) + 1'b1))); // R9

endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic              step,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              emerge
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic            en;
  logic            hit;
  logic [UP_W-1:0] upper_q;
  logic [CNT_W-1:0] low;
  op_e             op_q;
  logic            emerge_q;

  assign en  = !clk_en_n;
  assign hit = !sel1_n && sel2 && !sel3_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      upper_q  <= '0;
      emerge_q <= 1'b0;
    end else if (en) begin
      if (!step) begin
        upper_q  <= addr[ADDR_W-1:CNT_W];
        emerge_q <= hit && (op_q == OP_NONE);
        if (!hit)      op_q <= OP_NONE;
        else if (wr_n) op_q <= OP_RD;
        else           op_q <= OP_WR;
      end else begin
        emerge_q <= 1'b0;
      end
    end
  end

  zt_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (en && !step),
    .adv     (en && step && (op_q != OP_NONE)),
    .base_in (addr[CNT_W-1:0]),
    .ilv     (order_ilv),
    .low     (low)
  );

  assign op       = op_q;
  assign cur_addr = {upper_q, low};
  assign emerge   = emerge_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(op) && $stable(cur_addr) && $stable(emerge))); // R8
  AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step && !hit) |=> (op == OP_NONE)); // R1
  AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step) |=> (op == $past(op))); // R9
  AST_ADV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && op != OP_NONE) |=> (cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W]))); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (op == OP_NONE)); // R10

endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [LANES-1:0]          lane_we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*(LANE_W+1)-1:0] wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*(LANE_W+1)-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W:0] mem [DEPTH];
    logic [LANE_W:0] rd;

    always_ff @(posedge clk) begin
      if (we && lane_we[g])
        mem[waddr] <= {wdata[DATA_W+g], wdata[g*LANE_W +: LANE_W]};
    end

    assign rd                          = mem[raddr];
    assign rdata[g*LANE_W +: LANE_W]   = rd[LANE_W-1:0];
    assign rdata[DATA_W+g]             = rd[LANE_W];
  end

endmodule

// File: rtl/zt_drive.sv
module zt_drive
  import zt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  logic emerge,
  input  logic drive_en_n,
  output logic oe
);

  always_comb begin
    oe = 1'b0;
    if (!drive_en_n && op == OP_RD && !emerge) oe = 1'b1;
  end

  AST_WDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR) |-> !oe); // R6
  AST_EMERGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    emerge |-> !oe); // R6
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |-> !oe); // R6
  AST_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_n |-> !oe); // R7

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clk_en_n,
  input  logic                        sel1_n,
  input  logic                        sel2,
  input  logic                        sel3_n,
  input  logic                        wr_n,
  input  logic                        step,
  input  logic [LANES-1:0]            byte_wr_n,
  input  logic                        order_ilv,
  input  logic                        drive_en_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES*(LANE_W+1)-1:0] din,
  output logic [LANES*(LANE_W+1)-1:0] dout,
  output logic                        dout_oe
);

  localparam int CNT_W = 2;

  op_e               op;
  logic [ADDR_W-1:0] cur_addr;
  logic              emerge;
  logic              we;

  zt_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .wr_n      (wr_n),
    .step      (step),
    .order_ilv (order_ilv),
    .addr      (addr),
    .op        (op),
    .cur_addr  (cur_addr),
    .emerge    (emerge)
  );

  // Late write: data edge of the pending beat commits straight into the array
  assign we = !clk_en_n && (op == OP_WR);

  zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we      (we),
    .lane_we (~byte_wr_n),
    .waddr   (cur_addr),
    .wdata   (din),
    .raddr   (cur_addr),
    .rdata   (dout)
  );

  zt_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .emerge     (emerge),
    .drive_en_n (drive_en_n),
    .oe         (dout_oe)
  );

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |-> !we); // R8

endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;

  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en_n, sel1_n, sel2, sel3_n, wr_n, step, order_ilv, drive_en_n;
  logic [3:0]  byte_wr_n;
  logic [AW-1:0] addr;
  logic [35:0] din, dout;
  logic        dout_oe;

  always #4 clk = ~clk;

  zt_sram #(.ADDR_W(AW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .wr_n(wr_n), .step(step), .byte_wr_n(byte_wr_n),
    .order_ilv(order_ilv), .drive_en_n(drive_en_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  typedef struct {
    logic        chk;
    logic        eoe;
    logic [35:0] ed;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  localparam logic [35:0] D1 = 36'h9_1234_5678;
  localparam logic [35:0] D2 = 36'h6_89AB_CDEF;
  localparam logic [35:0] W0 = 36'hA_0000_1111;
  localparam logic [35:0] W1 = 36'h5_2222_3333;
  localparam logic [35:0] W2 = 36'h3_4444_5555;
  localparam logic [35:0] W3 = 36'hC_6666_7777;

  // Driver: one cycle of stimulus, plus the expected output after its edge
  task automatic cyc(input logic cen, input logic s1n, input logic s2, input logic s3n,
                     input logic wrn, input logic stp, input logic [3:0] bw,
                     input logic [AW-1:0] a, input logic [35:0] d, input logic oen,
                     input logic ilv, input logic eoe, input logic [35:0] ed,
                     input string tag);
    exp_t it;
    @(negedge clk);
    clk_en_n = cen; sel1_n = s1n; sel2 = s2; sel3_n = s3n; wr_n = wrn; step = stp;
    byte_wr_n = bw; addr = a; din = d; drive_en_n = oen; order_ilv = ilv;
    it.chk = 1'b1; it.eoe = eoe; it.ed = ed; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic ld(input logic wrn, input logic [AW-1:0] a, input logic [3:0] bw,
                    input logic [35:0] d, input logic ilv, input logic eoe,
                    input logic [35:0] ed, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, wrn, 1'b0, bw, a, d, 1'b0, ilv, eoe, ed, tag);
  endtask

  // Advance with junk selects, write command and address (all to be ignored)
  task automatic adv(input logic [3:0] bw, input logic [35:0] d, input logic ilv,
                     input logic oen, input logic eoe, input logic [35:0] ed,
                     input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, ~wr_n, 1'b1, bw, 8'hFF, d, oen, ilv, eoe, ed, tag);
  endtask

  // Monitor: compares the output away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        if (it.chk) begin
          total++;
          if (dout_oe !== it.eoe || (it.eoe && dout !== it.ed)) begin
            bad++;
            $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                     it.tag, dout_oe, dout, it.eoe, it.ed);
          end
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: finished=0 expected finished=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clk_en_n = 1'b1; sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1; wr_n = 1'b1;
    step = 1'b0; byte_wr_n = 4'hF; addr = '0; din = '0; drive_en_n = 1'b0;
    order_ilv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (dout_oe !== 1'b0) begin
      bad++;
      $display("FAIL R10 in reset: oe=%0b expected oe=0", dout_oe);
    end
    rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, '0, '0, 1'b0, 1'b0, 1'b0, '0, "R10 idle after reset");

    // Back-to-back writes then reads
    ld(1'b0, 8'h10, 4'hF, '0, 1'b0, 1'b0, '0, "R6 write data cycle");
    ld(1'b0, 8'h11, 4'h0, D1, 1'b0, 1'b0, '0, "R3 data edge loads next write");
    ld(1'b1, 8'h10, 4'h0, D2, 1'b0, 1'b1, D1, "R3 read right after write");
    ld(1'b1, 8'h11, 4'hF, '0, 1'b0, 1'b1, D2, "R2 back-to-back read");
    ld(1'b0, 8'h10, 4'hF, '0, 1'b0, 1'b0, '0, "R6 write data cycle masked");
    ld(1'b1, 8'h10, 4'b1010, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 36'hD_12FF_56FF, "R4 lanes 0,2 merged same address");

    // Deselect and emergence
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'h10, '0, 1'b0, 1'b0, 1'b0, '0, "R1 deselect output off");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 8'h10, '0, 1'b0, 1'b0, 1'b0, '0, "R9 advance while deselected");
    ld(1'b1, 8'h10, 4'hF, '0, 1'b0, 1'b0, '0, "R6 first cycle after deselect");
    adv(4'hF, '0, 1'b0, 1'b0, 1'b1, D2, "R9 linear advance 0->1");

    // Linear burst write with a stall in the last data phase
    ld(1'b0, 8'h21, 4'hF, '0, 1'b0, 1'b0, '0, "R6 burst write load");
    adv(4'h0, W0, 1'b0, 1'b0, 1'b0, '0, "R9 burst write beat 1");
    adv(4'h0, W1, 1'b0, 1'b0, 1'b0, '0, "R9 burst write beat 2");
    adv(4'h0, W2, 1'b0, 1'b0, 1'b0, '0, "R9 burst write beat 3");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0, "R8 stall keeps write pending");
    ld(1'b1, 8'h23, 4'h0, W3, 1'b0, 1'b1, W2, "R8 completion after stall, read 0x23");
    ld(1'b1, 8'h20, 4'hF, '0, 1'b0, 1'b1, W3, "R8 held write stored stall-free data");

    // Interleaved read burst
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 8'h00, '0, 1'b0, 1'b1, 1'b0, '0, "R1 deselect via sel3_n");
    ld(1'b1, 8'h21, 4'hF, '0, 1'b1, 1'b0, '0, "R6 emerge masks interleaved load");
    adv(4'hF, '0, 1'b1, 1'b0, 1'b1, W3, "R9 interleaved beat 1 -> 0x20");
    adv(4'hF, '0, 1'b1, 1'b0, 1'b1, W2, "R9 interleaved beat 2 -> 0x23");
    adv(4'hF, '0, 1'b1, 1'b1, 1'b0, '0, "R7 drive enable high");
    adv(4'hF, '0, 1'b1, 1'b0, 1'b1, W0, "R9 interleaved wrap -> 0x21");

    // Linear read burst with wrap
    ld(1'b1, 8'h22, 4'hF, '0, 1'b0, 1'b1, W1, "R2 linear load 0x22");
    adv(4'hF, '0, 1'b0, 1'b0, 1'b1, W2, "R9 linear -> 0x23");
    adv(4'hF, '0, 1'b0, 1'b0, 1'b1, W3, "R9 linear wrap -> 0x20");

    // Byte selects belong to the data edge
    ld(1'b0, 8'h20, 4'h0, '0, 1'b0, 1'b0, '0, "R5 address edge selects ignored");
    ld(1'b1, 8'h20, 4'b1110, 36'h0_0000_00AB, 1'b0, 1'b1, 36'hC_6666_77AB, "R5 data edge selects lane 0");

    // Deselected write stores nothing
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h21, '0, 1'b0, 1'b0, 1'b0, '0, "R1 write with sel2 low");
    ld(1'b1, 8'h20, 4'h0, '0, 1'b0, 1'b0, '0, "R6 emerge after failed write");
    ld(1'b1, 8'h21, 4'hF, '0, 1'b0, 1'b1, W0, "R1 deselected write left 0x21");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule